// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block sits between a host processor bus and the internal engine of a legacy PC keyboard controller. The host sees two byte-wide ports selected by one address bit. A write to either port lands in a one-byte input buffer, tagged with the port it came through. A read of the data port returns the output buffer, and a read of the other port returns an 8-bit status byte. The internal engine picks up host bytes with a valid/ready handshake. It posts keyboard or mouse bytes, with their error flags, through a second valid/ready handshake.

The host strobes are sampled into the block clock through a short synchronizer. A write takes effect once, when the synchronized strobe is first seen. The output buffer empties when a synchronized data-port read ends. The block raises one of two active-high interrupts while the output buffer holds a byte, choosing the keyboard line or the mouse line from the byte's source. The host data bus is split into input, output and output-enable so that the pad ring can build the bidirectional pin.

Top module: `kbc_host_if`

## Requirements
- R1: `a0`=1 selects the status port for reads and the command port for writes. `a0`=0 selects the data port. A status read returns the byte {bit7 parity error, bit6 time-out, bit5 aux, bit4 inhibit snapshot, bit3 command tag, bit2 system flag, bit1 input full, bit0 output full}. A data read returns the output buffer.
- R2: A host write to the command port sets status bit 3 and presents the byte with `ib_cmd`=1. A write to the data port clears bit 3 and presents the byte with `ib_cmd`=0. Bit 3 keeps its value after the byte is consumed.
- R3: Any host write sets input full (`ib_valid`, status bit 1). A write while the buffer is full replaces the byte. A cycle with `ib_valid` and `ib_ready` both high clears input full.
- R4: A cycle with `ob_valid` and `ob_ready` both high loads the output buffer and sets status bit 0. The end of a host data-port read clears bit 0.
- R5: The system flag (bit 2) is 0 after reset. A one-cycle `sys_ok_set` pulse sets it, and it stays set until reset.
- R6: Bit 4 holds the level of `kbd_inh` in the cycle the output buffer was loaded. Later changes of `kbd_inh` do not alter it.
- R7: Bits 5, 6 and 7 take `ob_aux`, `ob_tmo` and `ob_par` together with the byte.
- R8: `irq_kbd` is high while output full is 1 and aux is 0. `irq_mouse` is high while output full is 1 and aux is 1.
- R9: A status read changes no status bit. `host_doe` is high only while `cs_n` and `rd_n` are both low.
- R10: `ob_ready` is low while the output buffer is full. A posting attempted then is ignored, and the buffered byte stays in place.
- R11: After reset the status byte is 00h, both interrupts are low, `ob_ready` is 1 and `ib_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| a0 | input | 1 | Port select: 1 status/command, 0 data |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_doe | output | 1 | Drive enable for the host data pins |
| ib_valid | output | 1 | Input buffer holds a host byte |
| ib_data | output | 8 | Host byte |
| ib_cmd | output | 1 | Host byte came through the command port |
| ib_ready | input | 1 | Internal side takes the host byte |
| ob_valid | input | 1 | Internal side offers a byte |
| ob_ready | output | 1 | Output buffer can accept a byte |
| ob_data | input | 8 | Offered byte |
| ob_aux | input | 1 | Offered byte comes from the mouse |
| ob_tmo | input | 1 | Time-out error flag for the offered byte |
| ob_par | input | 1 | Parity error flag for the offered byte |
| kbd_inh | input | 1 | Keyboard inhibit level, captured on load |
| sys_ok_set | input | 1 | Pulse that sets the system flag |
| irq_kbd | output | 1 | Output buffer holds keyboard data |
| irq_mouse | output | 1 | Output buffer holds mouse data |

## Verification
The hardest case to reach from the ports is a posting attempt while the output buffer is full. The offered byte must leave no trace, and the only evidence of that is the byte and status seen on a later host read. The bench posts one byte and then holds `ob_valid` high with a different byte and different flags for several cycles. It then reads status and data to confirm that the first byte and its flags survived. The inhibit snapshot is checked in a similar way: `kbd_inh` is flipped right after each load, before the host reads status.

// File: rtl/kbc_pkg.sv
// Package: shared types for the keyboard controller host interface.
// Assumes: status byte is 8 bits with the bit order used by host software.
package kbc_pkg;

    typedef struct packed {
        logic par_err;   // bit 7
        logic tmo_err;   // bit 6
        logic aux;       // bit 5
        logic inh_snap;  // bit 4
        logic cmd_tag;   // bit 3
        logic sys_ok;    // bit 2
        logic in_full;   // bit 1
        logic out_full;  // bit 0
    } kbc_status_t;

endpackage

// File: rtl/kbc_strobe_sync.sv
// Module: kbc_strobe_sync
// Brings the asynchronous host strobes into the block clock. It gives a
// one-cycle write event with the port tag and data that were captured
// alongside, and a one-cycle event at the end of a data-port read.
// Assumes: strobes are held for at least STAGES+1 clock cycles, STAGES >= 2.
module kbc_strobe_sync #(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          a0,
    input  logic [DW-1:0] din,
    output logic          wr_ev,
    output logic          wr_cmd,
    output logic [DW-1:0] wr_data,
    output logic          rd_done
);

    localparam int LAST = STAGES - 1;
    localparam int PW   = DW + 1;

    logic [STAGES-1:0]         wr_sh;
    logic [STAGES-1:0]         rdd_sh;
    logic [STAGES-1:0][PW-1:0] pay_sh;
    logic                      wr_last;
    logic                      rdd_last;

    // Synchronizer chains for both strobes and the write payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sh    <= '0;
            rdd_sh   <= '0;
            pay_sh   <= '0;
            wr_last  <= 1'b0;
            rdd_last <= 1'b0;
        end else begin
            wr_sh[0]  <= ~cs_n & ~wr_n;
            rdd_sh[0] <= ~cs_n & ~rd_n & ~a0;
            pay_sh[0] <= {a0, din};
            for (int i = 1; i < STAGES; i++) begin
                wr_sh[i]  <= wr_sh[i-1];
                rdd_sh[i] <= rdd_sh[i-1];
                pay_sh[i] <= pay_sh[i-1];
            end
            wr_last  <= wr_sh[LAST];
            rdd_last <= rdd_sh[LAST];
        end
    end

    // Edge detection on the synchronized strobes.
    always_comb begin
        wr_ev   = wr_sh[LAST] & ~wr_last;
        rd_done = ~rdd_sh[LAST] & rdd_last;
        wr_cmd  = pay_sh[LAST][DW];
        wr_data = pay_sh[LAST][DW-1:0];
    end

endmodule

// File: rtl/kbc_in_buf.sv
// Module: kbc_in_buf
// One-byte input buffer that holds host writes. It keeps the full flag and
// the command/data tag. A new host write wins over a consume in the same
// cycle.
// Assumes: wr_ev is a single-cycle pulse.
module kbc_in_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ev,
    input  logic          wr_cmd,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic          cmd_tag,
    output logic [DW-1:0] data
);

    // Capture host bytes and clear the full flag on consume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= 1'b0;
            cmd_tag <= 1'b0;
            data    <= '0;
        end else if (wr_ev) begin
            full    <= 1'b1;
            cmd_tag <= wr_cmd;
            data    <= wr_data;
        end else if (take && full) begin
            full    <= 1'b0;
        end
    end

endmodule

// File: rtl/kbc_out_buf.sv
// Module: kbc_out_buf
// One-byte output buffer with source and error flags and the inhibit
// snapshot. It accepts a byte only while empty and empties when the host
// finishes reading it.
// Assumes: rd_done is a single-cycle pulse.
module kbc_out_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_valid,
    output logic          load_ready,
    input  logic [DW-1:0] load_data,
    input  logic          load_aux,
    input  logic          load_tmo,
    input  logic          load_par,
    input  logic          inh_lvl,
    input  logic          rd_done,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          aux,
    output logic          tmo,
    output logic          par,
    output logic          inh_snap
);

    logic do_load;

    // Accept a byte only while the buffer is empty.
    always_comb begin
        load_ready = ~full;
        do_load    = load_valid & ~full;
    end

    // Load the byte and its flags, and empty the buffer after a host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full     <= 1'b0;
            data     <= '0;
            aux      <= 1'b0;
            tmo      <= 1'b0;
            par      <= 1'b0;
            inh_snap <= 1'b0;
        end else if (do_load) begin
            full     <= 1'b1;
            data     <= load_data;
            aux      <= load_aux;
            tmo      <= load_tmo;
            par      <= load_par;
            inh_snap <= inh_lvl;
        end else if (rd_done && full) begin
            full     <= 1'b0;
        end
    end

endmodule

// File: rtl/kbc_host_if.sv
// Module: kbc_host_if
// Host-facing register interface of a keyboard controller. It holds the input
// and output buffers and the status byte, and drives the keyboard and mouse
// output-full interrupts.
// Assumes: host strobes stay active for several clock cycles; the bus pad is
// built outside from host_dout/host_doe.
module kbc_host_if #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          a0,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    output logic          host_doe,
    output logic          ib_valid,
    output logic [DW-1:0] ib_data,
    output logic          ib_cmd,
    input  logic          ib_ready,
    input  logic          ob_valid,
    output logic          ob_ready,
    input  logic [DW-1:0] ob_data,
    input  logic          ob_aux,
    input  logic          ob_tmo,
    input  logic          ob_par,
    input  logic          kbd_inh,
    input  logic          sys_ok_set,
    output logic          irq_kbd,
    output logic          irq_mouse
);
    import kbc_pkg::*;

    logic          wr_ev;
    logic          wr_cmd;
    logic [DW-1:0] wr_data;
    logic          rd_done;
    logic          obf;
    logic [DW-1:0] ob_byte;
    logic          ob_aux_q;
    logic          ob_tmo_q;
    logic          ob_par_q;
    logic          inh_q;
    logic          sys_ok_q;
    kbc_status_t   status;

    kbc_strobe_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .a0      (a0),
        .din     (host_din),
        .wr_ev   (wr_ev),
        .wr_cmd  (wr_cmd),
        .wr_data (wr_data),
        .rd_done (rd_done)
    );

    kbc_in_buf #(.DW(DW)) u_ibuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ev   (wr_ev),
        .wr_cmd  (wr_cmd),
        .wr_data (wr_data),
        .take    (ib_ready),
        .full    (ib_valid),
        .cmd_tag (ib_cmd),
        .data    (ib_data)
    );

    kbc_out_buf #(.DW(DW)) u_obuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (ob_valid),
        .load_ready (ob_ready),
        .load_data  (ob_data),
        .load_aux   (ob_aux),
        .load_tmo   (ob_tmo),
        .load_par   (ob_par),
        .inh_lvl    (kbd_inh),
        .rd_done    (rd_done),
        .full       (obf),
        .data       (ob_byte),
        .aux        (ob_aux_q),
        .tmo        (ob_tmo_q),
        .par        (ob_par_q),
        .inh_snap   (inh_q)
    );

    // System flag: set by the self-test pulse, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          sys_ok_q <= 1'b0;
        else if (sys_ok_set) sys_ok_q <= 1'b1;
    end

    // Assemble the status byte from the buffer states.
    always_comb begin
        status.par_err  = ob_par_q;
        status.tmo_err  = ob_tmo_q;
        status.aux      = ob_aux_q;
        status.inh_snap = inh_q;
        status.cmd_tag  = ib_cmd;
        status.sys_ok   = sys_ok_q;
        status.in_full  = ib_valid;
        status.out_full = obf;
    end

    // Host read mux and bus drive enable.
    always_comb begin
        host_doe  = ~cs_n & ~rd_n;
        host_dout = a0 ? DW'(status) : ob_byte;
    end

    // Output-full interrupts split by data source.
    always_comb begin
        irq_kbd   = obf & ~ob_aux_q;
        irq_mouse = obf & ob_aux_q;
    end

endmodule

// File: rtl/kbc_host_if_chk.sv
// Module: kbc_host_if_chk
// Property checker for kbc_host_if, attached by bind.
module kbc_host_if_chk (
    input logic clk,
    input logic rst_n,
    input logic ib_valid,
    input logic ib_ready,
    input logic ob_valid,
    input logic ob_ready,
    input logic irq_kbd,
    input logic irq_mouse
);

    // R8
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({irq_kbd, irq_mouse}) <= 1);

    // R10
    no_load_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_kbd || irq_mouse) |-> !ob_ready);

    // R4
    irq_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_kbd || irq_mouse) |-> $past(ob_valid && ob_ready));

    // R3
    ib_clear_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ib_valid) |-> $past(ib_ready));

endmodule

bind kbc_host_if kbc_host_if_chk u_chk (.*);

// File: tb/kbc_host_if_tb.sv
module kbc_host_if_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic       host_doe;
    logic       ib_valid, ib_cmd, ob_ready, irq_kbd, irq_mouse;
    logic [7:0] ib_data;
    logic       ib_ready = 1'b0, ob_valid = 1'b0;
    logic [7:0] ob_data = '0;
    logic       ob_aux = 1'b0, ob_tmo = 1'b0, ob_par = 1'b0;
    logic       kbd_inh = 1'b0, sys_ok_set = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbc_host_if u_dut (.*);

    // {data, aux, tmo, par, inh, expected status, exp irq_kbd, exp irq_mouse}
    localparam logic [21:0] VEC [5] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 1'b1, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA1, 1'b0, 1'b1},
        {8'hFE, 1'b0, 1'b1, 1'b0, 1'b1, 8'h51, 1'b1, 1'b0},
        {8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 8'hF1, 1'b0, 1'b1},
        {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic port, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; a0 = port; host_din = d;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(input logic port, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a0 = port;
        repeat (2) @(negedge clk);
        d  = host_dout;
        oe = host_doe;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic post(input logic [7:0] d, input logic aux, input logic tmo,
                        input logic par, input logic inh);
        @(negedge clk);
        ob_data = d; ob_aux = aux; ob_tmo = tmo; ob_par = par; kbd_inh = inh;
        ob_valid = 1'b1;
        @(negedge clk);
        ob_valid = 1'b0;
        kbd_inh = ~inh;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv, rv2;
        logic       oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 irq", {6'd0, irq_kbd, irq_mouse}, 8'h00);
        chk("R11 ready", {6'd0, ob_ready, ib_valid}, 8'h02);
        chk("R9 doe idle", {7'd0, host_doe}, 8'h00);
        host_read(1'b1, rv, oe);
        chk("R11 status", rv, 8'h00);
        chk("R9 doe on read", {7'd0, oe}, 8'h01);

        // Table walk: R4 R6 R7 R8 R1
        for (int i = 0; i < 5; i++) begin
            logic [21:0] v;
            v = VEC[i];
            post(v[21:14], v[13], v[12], v[11], v[10]);
            chk("R10 ready low", {7'd0, ob_ready}, 8'h00);
            chk("R8 irqs", {6'd0, irq_kbd, irq_mouse}, {6'd0, v[1], v[0]});
            host_read(1'b1, rv, oe);
            chk("R6 R7 status", rv, v[9:2]);
            host_read(1'b0, rv, oe);
            chk("R1 data", rv, v[21:14]);
            chk("R4 cleared", {5'd0, irq_kbd, irq_mouse, ob_ready}, 8'h01);
            host_read(1'b1, rv, oe);
            chk("R4 status obf", {7'd0, rv[0]}, 8'h00);
        end

        // R2 R3 data-port write
        host_write(1'b0, 8'h12);
        chk("R3 ib data", ib_data, 8'h12);
        chk("R2 tag data", {6'd0, ib_valid, ib_cmd}, 8'h02);
        host_read(1'b1, rv, oe);
        chk("R2 status data", rv & 8'h0E, 8'h02);

        // R2 R3 command write overwrites
        host_write(1'b1, 8'hAA);
        chk("R3 overwrite", ib_data, 8'hAA);
        chk("R2 tag cmd", {6'd0, ib_valid, ib_cmd}, 8'h03);

        // R3 consume
        @(negedge clk); ib_ready = 1'b1;
        @(negedge clk); ib_ready = 1'b0;
        chk("R3 consumed", {7'd0, ib_valid}, 8'h00);
        host_read(1'b1, rv, oe);
        chk("R2 tag kept", rv & 8'h0E, 8'h08);

        // R5 system flag
        @(negedge clk); sys_ok_set = 1'b1;
        @(negedge clk); sys_ok_set = 1'b0;
        host_read(1'b1, rv, oe);
        chk("R5 sysflag", rv & 8'h0E, 8'h0C);

        // R9 status reads change nothing
        post(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1);
        host_read(1'b1, rv, oe);
        host_read(1'b1, rv2, oe);
        chk("R9 status stable", rv2, rv);
        chk("R9 obf kept", {7'd0, irq_mouse}, 8'h01);

        // R10 posting while full ignored
        @(negedge clk);
        ob_data = 8'hC3; ob_aux = 1'b0; ob_tmo = 1'b1; ob_par = 1'b1; kbd_inh = 1'b0;
        ob_valid = 1'b1;
        repeat (4) @(negedge clk);
        ob_valid = 1'b0;
        host_read(1'b1, rv, oe);
        chk("R10 status kept", rv, 8'h3D);
        host_read(1'b0, rv, oe);
        chk("R10 data kept", rv, 8'h5A);

        // R9 bus not driven without select or during write
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        chk("R9 doe no cs", {7'd0, host_doe}, 8'h00);
        rd_n = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        chk("R9 doe write", {7'd0, host_doe}, 8'h00);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule